// File: doc/BRIEF.md
# Bus-Organized Register Datapath

This block is a compact execution datapath built around seven general-purpose registers. Each clock cycle, a single control word picks two sources, an ALU operation and a destination. The two sources drive a pair of operand buses, A and B. The ALU combines the two bus values, and the result is written back into the chosen register on the next rising edge. Control-word generation and sequencing are left to the surrounding logic. The datapath executes exactly one microoperation per control word.

Source code 000 does not select a register. It selects an external data input. The same code in the destination field suppresses write-back, so the result is only observed on the external result port. That port always shows the current ALU result, combinationally. A four-bit flag register records carry, sign, zero and overflow for the word executed in each clock.

Top module: `regbus_datapath`

## Requirements
- R1: A synchronous active-high reset clears all seven registers and the flag register to zero.
- R2: The 14-bit control word is split into four fields: bus-A source [13:11], bus-B source [10:8], destination [7:5] and operation [4:0]. A source or destination code k from 1 to 7 names register Rk. For example, A=2, B=3, operation add and destination 1 performs R1 = R2 + R3 in one clock.
- R3: A source code of 000 puts the external data input on that bus instead of a register.
- R4: A nonzero destination code loads the ALU result into that register on the rising edge. All other registers keep their values.
- R5: A destination code of 000 writes no register, while the result still appears on the result port.
- R6: The result port follows the current register contents, the external input and the control word in the same cycle, with no register in the path.
- R7: Arithmetic codes work modulo 256: 00000 passes A, 00001 gives A+1, 00010 gives A+B, 00101 gives A-B, 00110 gives A-1.
- R8: Logic codes: 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B, 01110 gives NOT A. XOR of a register with itself gives zero, so it can clear a register.
- R9: Code 10000 shifts A right by one, and code 11000 shifts A left by one. In both cases a zero enters the vacated bit.
- R10: Any other operation code passes A through unchanged.
- R11: The flag output is laid out as flags[3]=C, flags[2]=S, flags[1]=Z and flags[0]=V. It is reloaded on every clock out of reset from that cycle's result. S is result bit 7, and Z is 1 exactly when the result is all zeros.
- R12: For the arithmetic operations, C is the carry out of bit 7. Subtract is formed as A + NOT B + 1, and decrement as A + 0xFF. V is the XOR of the carry into and out of bit 7. Shifts set C to the bit shifted out and clear V. Every other operation clears both C and V.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 14 | Microoperation control word |
| ext_in | input | 8 | External data, selected by source code 000 |
| alu_out | output | 8 | Combinational ALU result |
| flags | output | 4 | Registered C, S, Z, V |

## Verification
The ALU result is due in the same cycle as its control word. The bench drives each word on a falling edge and samples `alu_out` one nanosecond later. Register write-back and the flags are due after the next rising edge. The flags are therefore compared at the following falling edge, at which point a no-write word is put on the inputs so the operation is not repeated. Register contents are read back through a transfer word with destination 000, again sampled within the cycle that word is applied.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  typedef enum logic [4:0] {
    OP_XFER = 5'b00000,
    OP_INC  = 5'b00001,
    OP_ADD  = 5'b00010,
    OP_SUB  = 5'b00101,
    OP_DEC  = 5'b00110,
    OP_AND  = 5'b01000,
    OP_OR   = 5'b01010,
    OP_XOR  = 5'b01100,
    OP_NOT  = 5'b01110,
    OP_SHR  = 5'b10000,
    OP_SHL  = 5'b11000
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic v;
  } flags_t;
endpackage

// File: rtl/rbd_regfile.sv
module rbd_regfile #(
  parameter int DATA_W = 8,
  parameter int NREG   = 7,
  parameter int SEL_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SEL_W-1:0]       wr_sel,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [NREG*DATA_W-1:0] rf_flat
);
  logic [DATA_W-1:0] mem [1:NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 1; k <= NREG; k++) mem[k] <= '0;
    end else begin
      for (int k = 1; k <= NREG; k++)
        if (wr_sel == SEL_W'(k)) mem[k] <= wr_data;
    end
  end

  for (genvar g = 1; g <= NREG; g++) begin : g_flat
    assign rf_flat[(g-1)*DATA_W +: DATA_W] = mem[g];
  end
endmodule

// File: rtl/rbd_bus_sel.sv
module rbd_bus_sel #(
  parameter int DATA_W = 8,
  parameter int NREG   = 7,
  parameter int SEL_W  = 3
) (
  input  logic [SEL_W-1:0]       sel,
  input  logic [DATA_W-1:0]      ext_in,
  input  logic [NREG*DATA_W-1:0] rf_flat,
  output logic [DATA_W-1:0]      bus
);
  always_comb begin
    bus = ext_in;
    for (int k = 1; k <= NREG; k++)
      if (sel == SEL_W'(k)) bus = rf_flat[(k-1)*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/rbd_alu.sv
module rbd_alu
  import rbd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OP_W   = 5
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              carry,
  output logic              ovf
);
  logic [DATA_W-1:0] add_y;
  logic              add_ci;
  logic              is_arith;
  logic [DATA_W:0]   full_sum;
  logic [DATA_W-1:0] low_sum;

  // operand preparation for the shared adder
  always_comb begin
    add_y    = '0;
    add_ci   = 1'b0;
    is_arith = 1'b0;
    case (op)
      OP_INC: begin is_arith = 1'b1; add_ci = 1'b1; end
      OP_ADD: begin is_arith = 1'b1; add_y = b; end
      OP_SUB: begin is_arith = 1'b1; add_y = ~b; add_ci = 1'b1; end
      OP_DEC: begin is_arith = 1'b1; add_y = '1; end
      default: ;
    endcase
  end

  assign full_sum = {1'b0, a} + {1'b0, add_y} + {{DATA_W{1'b0}}, add_ci};
  assign low_sum  = {1'b0, a[DATA_W-2:0]} + {1'b0, add_y[DATA_W-2:0]}
                  + {{(DATA_W-1){1'b0}}, add_ci};

  always_comb begin
    res   = a;
    carry = 1'b0;
    ovf   = 1'b0;
    if (is_arith) begin
      res   = full_sum[DATA_W-1:0];
      carry = full_sum[DATA_W];
      ovf   = full_sum[DATA_W] ^ low_sum[DATA_W-1];
    end else begin
      case (op)
        OP_AND: res = a & b;
        OP_OR:  res = a | b;
        OP_XOR: res = a ^ b;
        OP_NOT: res = ~a;
        OP_SHR: begin res = {1'b0, a[DATA_W-1:1]}; carry = a[0]; end
        OP_SHL: begin res = {a[DATA_W-2:0], 1'b0}; carry = a[DATA_W-1]; end
        default: res = a;
      endcase
    end
  end
endmodule

// File: rtl/rbd_flags.sv
module rbd_flags
  import rbd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] res,
  input  logic              carry,
  input  logic              ovf,
  output flags_t            q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else begin
      q.c <= carry;
      q.s <= res[DATA_W-1];
      q.z <= (res == '0);
      q.v <= ovf;
    end
  end
endmodule

// File: rtl/regbus_datapath.sv
module regbus_datapath
  import rbd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NREG   = 7,
  parameter int OP_W   = 5,
  localparam int SEL_W = $clog2(NREG + 1),
  localparam int CW_W  = 3 * SEL_W + OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW_W-1:0]   ctrl_word,
  input  logic [DATA_W-1:0] ext_in,
  output logic [DATA_W-1:0] alu_out,
  output logic [3:0]        flags
);
  logic [SEL_W-1:0]       src_sel [2];
  logic [DATA_W-1:0]      src_bus [2];
  logic [SEL_W-1:0]       sel_d;
  logic [OP_W-1:0]        op;
  logic [NREG*DATA_W-1:0] rf_flat;
  logic                   carry, ovf;
  flags_t                 flag_q;

  assign src_sel[0] = ctrl_word[CW_W-1 -: SEL_W];
  assign src_sel[1] = ctrl_word[CW_W-1-SEL_W -: SEL_W];
  assign sel_d      = ctrl_word[OP_W +: SEL_W];
  assign op         = ctrl_word[OP_W-1:0];

  rbd_regfile #(.DATA_W(DATA_W), .NREG(NREG), .SEL_W(SEL_W)) u_rf (
    .clk(clk), .rst(rst), .wr_sel(sel_d), .wr_data(alu_out), .rf_flat(rf_flat)
  );

  for (genvar g = 0; g < 2; g++) begin : g_bus
    rbd_bus_sel #(.DATA_W(DATA_W), .NREG(NREG), .SEL_W(SEL_W)) u_sel (
      .sel(src_sel[g]), .ext_in(ext_in), .rf_flat(rf_flat), .bus(src_bus[g])
    );
  end

  rbd_alu #(.DATA_W(DATA_W), .OP_W(OP_W)) u_alu (
    .op(op), .a(src_bus[0]), .b(src_bus[1]),
    .res(alu_out), .carry(carry), .ovf(ovf)
  );

  rbd_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst(rst), .res(alu_out), .carry(carry), .ovf(ovf), .q(flag_q)
  );

  assign flags = flag_q;
endmodule

// File: rtl/rbd_checker.sv
module rbd_checker #(
  parameter int DATA_W = 8,
  parameter int NREG   = 7,
  parameter int SEL_W  = 3,
  parameter int OP_W   = 5,
  parameter int CW_W   = 14
) (
  input logic                   clk,
  input logic                   rst,
  input logic [CW_W-1:0]        ctrl_word,
  input logic [DATA_W-1:0]      alu_out,
  input logic [3:0]             flags,
  input logic [NREG*DATA_W-1:0] rf_flat
);
  logic                   past_valid;
  logic [NREG*DATA_W-1:0] prev_rf;
  logic [DATA_W-1:0]      prev_alu;
  logic [SEL_W-1:0]       prev_d;

  always_ff @(posedge clk) begin
    past_valid <= !rst;
    prev_rf    <= rf_flat;
    prev_alu   <= alu_out;
    prev_d     <= ctrl_word[OP_W +: SEL_W];
  end

  function automatic logic [DATA_W-1:0] slice_of(input logic [NREG*DATA_W-1:0] v,
                                                 input logic [SEL_W-1:0] d);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int k = 1; k <= NREG; k++)
      if (d == SEL_W'(k)) r = v[(k-1)*DATA_W +: DATA_W];
    return r;
  endfunction

  function automatic int n_changed(input logic [NREG*DATA_W-1:0] x,
                                   input logic [NREG*DATA_W-1:0] y);
    int n;
    n = 0;
    for (int k = 0; k < NREG; k++)
      if (x[k*DATA_W +: DATA_W] != y[k*DATA_W +: DATA_W]) n++;
    return n;
  endfunction

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (flags == 4'b0 && rf_flat == '0));

  assert_dest_write_R4: assert property (@(posedge clk) disable iff (rst)
    (past_valid && prev_d != '0) |-> slice_of(rf_flat, prev_d) == prev_alu);

  assert_single_write_R4: assert property (@(posedge clk) disable iff (rst)
    past_valid |-> n_changed(rf_flat, prev_rf) <= 1);

  assert_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (past_valid && prev_d == '0) |-> rf_flat == prev_rf);

  assert_flag_sz_R11: assert property (@(posedge clk) disable iff (rst)
    past_valid |-> (flags[1] == (prev_alu == '0) && flags[2] == prev_alu[DATA_W-1]));

  assert_xor_self_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_word[OP_W-1:0] == rbd_pkg::OP_XOR &&
     ctrl_word[CW_W-1 -: SEL_W] == ctrl_word[CW_W-1-SEL_W -: SEL_W]) |-> alu_out == '0);
endmodule

bind regbus_datapath rbd_checker #(
  .DATA_W(DATA_W), .NREG(NREG), .SEL_W(SEL_W), .OP_W(OP_W), .CW_W(CW_W)
) u_chk (
  .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .alu_out(alu_out),
  .flags(flags), .rf_flat(rf_flat)
);

// File: tb/regbus_datapath_bench.sv
module regbus_datapath_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [13:0] cw;
  logic [7:0]  ext;
  logic [7:0]  alu_out;
  logic [3:0]  flags;
  logic [7:0]  shadow [1:7];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  localparam logic [4:0] XFER = 5'b00000, INC = 5'b00001, ADD = 5'b00010,
                         SUB = 5'b00101, DEC = 5'b00110, AND_ = 5'b01000,
                         OR_ = 5'b01010, XOR_ = 5'b01100, NOT_ = 5'b01110,
                         SHR = 5'b10000, SHL = 5'b11000;

  always #4 clk = ~clk;

  regbus_datapath u_regbus_datapath (
    .clk(clk), .rst(rst), .ctrl_word(cw), .ext_in(ext),
    .alu_out(alu_out), .flags(flags)
  );

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // returns {C, V, result}
  function automatic logic [9:0] model(input logic [4:0] op,
                                       input logic [7:0] a, input logic [7:0] b);
    logic [7:0] y, r;
    logic       ci, c, v;
    logic [8:0] s;
    y = 8'h00; ci = 1'b0; c = 1'b0; v = 1'b0; r = a;
    case (op)
      XFER: r = a;
      INC, ADD, SUB, DEC: begin
        if (op == INC) ci = 1'b1;
        if (op == ADD) y = b;
        if (op == SUB) begin y = ~b; ci = 1'b1; end
        if (op == DEC) y = 8'hFF;
        s = {1'b0, a} + {1'b0, y} + {8'h00, ci};
        r = s[7:0];
        c = s[8];
        v = (a[7] == y[7]) && (r[7] != a[7]);
      end
      AND_: r = a & b;
      OR_:  r = a | b;
      XOR_: r = a ^ b;
      NOT_: r = ~a;
      SHR:  begin r = a >> 1; c = a[0]; end
      SHL:  begin r = a << 1; c = a[7]; end
      default: r = a;
    endcase
    return {c, v, r};
  endfunction

  task automatic run_op(input logic [2:0] sa, input logic [2:0] sb,
                        input logic [2:0] sd, input logic [4:0] op,
                        input logic [7:0] ex, input string tag);
    logic [7:0] a, b;
    logic [9:0] m;
    @(negedge clk);
    cw = {sa, sb, sd, op};
    ext = ex;
    #1;
    a = (sa == 3'd0) ? ex : shadow[sa];
    b = (sb == 3'd0) ? ex : shadow[sb];
    m = model(op, a, b);
    chk({tag, " R6"}, "alu_out", alu_out, m[7:0]);
    @(negedge clk);
    cw = 14'h0000;
    ext = 8'h00;
    chk({tag, " R11 R12"}, "flags", {4'h0, flags},
        {4'h0, m[9], m[7], (m[7:0] == 8'h00), m[8]});
    if (sd != 3'd0) shadow[sd] = m[7:0];
  endtask

  task automatic read_all(input string tag);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      cw = {3'(k), 3'd0, 3'd0, XFER};
      #1;
      chk(tag, $sformatf("R%0d readback", k), alu_out, shadow[k]);
    end
  endtask

  task automatic t_reset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    cw = 14'h0000;
    ext = 8'h00;
    repeat (2) @(negedge clk);
    chk({tag, " R1"}, "flags in reset", {4'h0, flags}, 8'h00);
    rst = 1'b0;
    for (int k = 1; k <= 7; k++) shadow[k] = 8'h00;
    read_all({tag, " R1"});
  endtask

  task automatic t_load;
    logic [7:0] vals [1:7];
    vals[1] = 8'h7F; vals[2] = 8'h12; vals[3] = 8'h34; vals[4] = 8'hFF;
    vals[5] = 8'h80; vals[6] = 8'h01; vals[7] = 8'hA5;
    for (int k = 1; k <= 7; k++)
      run_op(3'd0, 3'd0, 3'(k), XFER, vals[k], "R3 R4 load ext");
    read_all("R4 R2 load readback");
  endtask

  task automatic t_arith;
    run_op(3'd2, 3'd3, 3'd1, ADD, 8'h00, "R2 R7 add R1=R2+R3");
    read_all("R2 R4 after add");
    run_op(3'd5, 3'd6, 3'd2, SUB, 8'h00, "R7 R12 sub overflow");
    run_op(3'd6, 3'd4, 3'd0, ADD, 8'h00, "R7 R12 add carry to zero");
    run_op(3'd5, 3'd0, 3'd3, DEC, 8'h00, "R7 R12 dec");
    run_op(3'd0, 3'd6, 3'd0, SUB, 8'h00, "R3 R7 R12 sub borrow ext on A");
    run_op(3'd3, 3'd0, 3'd3, INC, 8'h00, "R7 R12 inc to 0x80 overflow");
    run_op(3'd6, 3'd0, 3'd6, DEC, 8'h00, "R7 R12 dec to zero");
    run_op(3'd7, 3'd0, 3'd0, ADD, 8'h5B, "R3 R7 ext on B");
    read_all("R4 after arith");
  endtask

  task automatic t_logic;
    run_op(3'd7, 3'd2, 3'd0, AND_, 8'h00, "R8 and");
    run_op(3'd7, 3'd1, 3'd0, OR_,  8'h00, "R8 or");
    run_op(3'd7, 3'd4, 3'd0, XOR_, 8'h00, "R8 xor");
    run_op(3'd7, 3'd0, 3'd0, NOT_, 8'h00, "R8 not");
    run_op(3'd7, 3'd7, 3'd7, XOR_, 8'h00, "R8 xor self clear");
    read_all("R8 after clear");
  endtask

  task automatic t_shift;
    run_op(3'd4, 3'd0, 3'd6, SHR, 8'h00, "R9 shr");
    run_op(3'd4, 3'd0, 3'd7, SHL, 8'h00, "R9 shl");
    run_op(3'd2, 3'd0, 3'd0, SHL, 8'h00, "R9 shl even");
    read_all("R9 after shifts");
  endtask

  task automatic t_undef;
    run_op(3'd4, 3'd1, 3'd0, 5'b00011, 8'h00, "R10 undefined 00011");
    run_op(3'd5, 3'd1, 3'd0, 5'b11111, 8'h00, "R10 undefined 11111");
  endtask

  task automatic t_nowrite;
    run_op(3'd1, 3'd4, 3'd0, ADD, 8'h00, "R5 no write-back");
    run_op(3'd0, 3'd0, 3'd0, XFER, 8'hC3, "R5 ext to output only");
    read_all("R5 registers unchanged");
  endtask

  initial begin
    #(8 * 50000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    cw = 14'h0000;
    ext = 8'h00;
    for (int k = 1; k <= 7; k++) shadow[k] = 8'h00;
    t_reset("initial");
    t_load();
    t_arith();
    t_logic();
    t_shift();
    t_undef();
    t_nowrite();
    t_reset("mid-run");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule